// File: doc/BRIEF.md
# Multi-Buffer DMA Descriptor Sequencer

This block is the control sequencer of one DMA channel that moves a chain of buffers. Software supplies a first set of fields: a source address, a destination address, a control word and a next-descriptor pointer. It then pulses a start input. The sequencer hands each buffer to an external data mover through a start/done handshake. Each time a buffer completes, it decides where the next buffer's fields come from.

Two bits in the control word make that decision, one for each side. When a side's bit is 0, that side's next address is loaded from a four-word descriptor in memory, read over a simple request/acknowledge port. When a side's bit is 1, that side's next address continues from the final address the mover reported. The size, control word and next pointer of every follow-on buffer always come from the descriptor. When a buffer completes with both bits at 1, it was the final buffer and the channel goes idle.

Sticky status bits record each completed buffer and the end of the chain. A one-cycle pulse clears each of them. Each status bit is gated by its own mask input onto an interrupt output.

Top module: `dma_chain_seq`

## Requirements
- R1: A start pulse while idle loads the user source, destination, control and next inputs. It raises `busy`, then drives `mv_start` high for exactly one cycle. During that cycle `mv_src`, `mv_dst` and `mv_size` carry the user values, where the size is control bits [15:0].
- R2: A buffer that completes while control bit 16 (source-continue) and bit 17 (destination-continue) are both 1 ends the channel. `busy` falls, no descriptor is read and no further `mv_start` is issued.
- R3: When a buffer completes with bit 16 = 0 and bit 17 = 1, the next buffer takes its source address, size and control from the descriptor. Its destination address equals the `mv_dst_end` reported at that completion.
- R4: When a buffer completes with bit 16 = 1 and bit 17 = 0, the next buffer takes its destination address, size and control from the descriptor. Its source address equals the `mv_src_end` reported at that completion.
- R5: When a buffer completes with bits 16 and 17 both 0, the next buffer takes source, destination, size and control all from the descriptor.
- R6: A descriptor is read as four word reads at next, next+4, next+8 and next+12, in that order. The words are source, destination, control and next pointer. Each request holds its address until `mem_ack` is seen.
- R7: Every buffer completion sets `sts_buf`. `irq_buf` equals `sts_buf` AND `irq_mask_buf`.
- R8: `sts_chain` is set only by the completion of the final buffer, never by an earlier one. `irq_chain` equals `sts_chain` AND `irq_mask_chain`.
- R9: A one-cycle `clr_buf` or `clr_chain` pulse clears the matching status bit. If a clear and a set fall in the same cycle, the set wins.
- R10: A start pulse while `busy` is high is ignored. The chain in progress keeps its fields and its buffer count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a chain with the user fields |
| usr_src | input | 32 | User source address |
| usr_dst | input | 32 | User destination address |
| usr_ctrl | input | 32 | User control word (size [15:0], continue bits 16/17) |
| usr_next | input | 32 | User next-descriptor pointer |
| busy | output | 1 | Channel active |
| mv_start | output | 1 | One-cycle buffer launch to the mover |
| mv_src | output | 32 | Buffer source address |
| mv_dst | output | 32 | Buffer destination address |
| mv_size | output | 16 | Buffer size in transfer units |
| mv_done | input | 1 | Mover finished the current buffer |
| mv_src_end | input | 32 | Source address after the last transfer |
| mv_dst_end | input | 32 | Destination address after the last transfer |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read data valid for the current request |
| mem_rdata | input | 32 | Read data |
| irq_mask_buf | input | 1 | Buffer interrupt mask |
| irq_mask_chain | input | 1 | End-of-chain interrupt mask |
| clr_buf | input | 1 | Write-one-to-clear pulse for buffer status |
| clr_chain | input | 1 | Write-one-to-clear pulse for chain status |
| sts_buf | output | 1 | Sticky buffer-complete status |
| sts_chain | output | 1 | Sticky end-of-chain status |
| irq_buf | output | 1 | Masked buffer interrupt |
| irq_chain | output | 1 | Masked end-of-chain interrupt |

## Verification
The assertions assume that the mover raises `mv_done` only once per launch and only while a buffer is outstanding. They also assume that `mem_ack` arrives only against a pending `mem_req`, and that every next pointer is word aligned. The bench models a mover that answers each launch with a single done pulse a few cycles later. Its memory model acknowledges only pending requests. All its descriptor pointers are multiples of 16.

// File: rtl/dcs_pkg.sv
// Shared constants and types for the descriptor sequencer.
// Assumes 32-bit addresses and a 32-bit descriptor word.
package dcs_pkg;
    localparam int DW         = 32;
    localparam int SIZE_W     = 16;
    localparam int SRC_CONT_B = 16;
    localparam int DST_CONT_B = 17;
    localparam int DESC_WORDS = 4;
    localparam int WIDX_W     = $clog2(DESC_WORDS);

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_RUN    = 2'd2,
        SQ_FETCH  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] nxt;
    } desc_t;
endpackage

// File: rtl/dcs_fetch.sv
// Descriptor fetcher: on go, reads DESC_WORDS consecutive words from base.
// Holds each request until ack, then pulses done for one cycle with all
// words assembled. Assumes base is word aligned and ack only answers req.
module dcs_fetch
    import dcs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] base,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output desc_t         desc
);
    logic              active;
    logic [WIDX_W-1:0] idx;
    logic [DW-1:0]     base_r;
    logic [DW-1:0]     words [DESC_WORDS];

    // Walk the word index and capture each acknowledged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base_r <= '0;
            done   <= 1'b0;
            for (int i = 0; i < DESC_WORDS; i++) words[i] <= '0;
        end else begin
            done <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                idx    <= '0;
                base_r <= base;
            end else if (active && mem_ack) begin
                words[idx] <= mem_rdata;
                idx        <= idx + 1'b1;
                if (idx == WIDX_W'(DESC_WORDS - 1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // Request address is base plus the word index in bytes.
    always_comb begin
        mem_req  = active;
        mem_addr = base_r + {{(DW-WIDX_W-2){1'b0}}, idx, 2'b00};
    end

    // Word order in memory: source, destination, control, next pointer.
    always_comb begin
        desc.src  = words[0];
        desc.dst  = words[1];
        desc.ctrl = words[2];
        desc.nxt  = words[3];
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R6
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R6
endmodule

// File: rtl/dcs_ctx.sv
// Channel context: holds the live descriptor and the continuation addresses.
// Loads user fields on start, captures mover end addresses on buffer done,
// and on a descriptor load picks each side from memory or continuation
// according to the continue bits of the buffer that just finished.
module dcs_ctx
    import dcs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_usr,
    input  desc_t         usr,
    input  logic          capture_end,
    input  logic [DW-1:0] src_end,
    input  logic [DW-1:0] dst_end,
    input  logic          load_lli,
    input  desc_t         lli,
    output desc_t         cur
);
    logic [DW-1:0] cont_src;
    logic [DW-1:0] cont_dst;

    // Remember where each side stopped on the buffer just completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_src <= '0;
            cont_dst <= '0;
        end else if (capture_end) begin
            cont_src <= src_end;
            cont_dst <= dst_end;
        end
    end

    // Update the live descriptor from user inputs or from a fetched item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load_usr) begin
            cur <= usr;
        end else if (load_lli) begin
            cur.src  <= cur.ctrl[SRC_CONT_B] ? cont_src : lli.src;
            cur.dst  <= cur.ctrl[DST_CONT_B] ? cont_dst : lli.dst;
            cur.ctrl <= lli.ctrl;
            cur.nxt  <= lli.nxt;
        end
    end
endmodule

// File: rtl/dcs_irq.sv
// Sticky status with write-one-to-clear pulses and mask gating.
// A set and a clear in the same cycle leave the bit set.
module dcs_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_buf,
    input  logic set_chain,
    input  logic clr_buf,
    input  logic clr_chain,
    input  logic mask_buf,
    input  logic mask_chain,
    output logic sts_buf,
    output logic sts_chain,
    output logic irq_buf,
    output logic irq_chain
);
    // Hold each status until cleared; setting takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_buf   <= 1'b0;
            sts_chain <= 1'b0;
        end else begin
            if (set_buf)        sts_buf <= 1'b1;
            else if (clr_buf)   sts_buf <= 1'b0;
            if (set_chain)      sts_chain <= 1'b1;
            else if (clr_chain) sts_chain <= 1'b0;
        end
    end

    // Gate the status bits onto the interrupt lines.
    always_comb begin
        irq_buf   = sts_buf & mask_buf;
        irq_chain = sts_chain & mask_chain;
    end

    AST_BUF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_buf |=> sts_buf); // R9
    AST_CHAIN_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_chain |=> sts_chain); // R9
    AST_CLR_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        clr_buf && !set_buf |=> !sts_buf); // R9
endmodule

// File: rtl/dma_chain_seq.sv
// Per-channel multi-buffer sequencer. Launches one buffer at a time on the
// mover; after each done it ends the chain (both continue bits set) or reads
// the next descriptor and launches again. Assumes mv_done pulses once per
// launch while a buffer is outstanding, and pointers are word aligned.
module dma_chain_seq
    import dcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     usr_src,
    input  logic [DW-1:0]     usr_dst,
    input  logic [DW-1:0]     usr_ctrl,
    input  logic [DW-1:0]     usr_next,
    output logic              busy,
    output logic              mv_start,
    output logic [DW-1:0]     mv_src,
    output logic [DW-1:0]     mv_dst,
    output logic [SIZE_W-1:0] mv_size,
    input  logic              mv_done,
    input  logic [DW-1:0]     mv_src_end,
    input  logic [DW-1:0]     mv_dst_end,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              irq_mask_buf,
    input  logic              irq_mask_chain,
    input  logic              clr_buf,
    input  logic              clr_chain,
    output logic              sts_buf,
    output logic              sts_chain,
    output logic              irq_buf,
    output logic              irq_chain
);
    seq_state_t state;
    desc_t      cur;
    desc_t      usr;
    desc_t      lli;
    logic       fetch_go;
    logic       fetch_done;
    logic       load_usr;
    logic       buf_end;
    logic       is_last;

    // Decode sequencing events from the state and handshakes.
    always_comb begin
        usr      = '{src: usr_src, dst: usr_dst, ctrl: usr_ctrl, nxt: usr_next};
        load_usr = start && (state == SQ_IDLE);
        buf_end  = mv_done && (state == SQ_RUN);
        is_last  = cur.ctrl[SRC_CONT_B] && cur.ctrl[DST_CONT_B];
        fetch_go = buf_end && !is_last;
    end

    // Channel state machine: launch, wait for done, fetch, relaunch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            unique case (state)
                SQ_IDLE:   if (start)      state <= SQ_LAUNCH;
                SQ_LAUNCH:                 state <= SQ_RUN;
                SQ_RUN:    if (mv_done)    state <= is_last ? SQ_IDLE : SQ_FETCH;
                SQ_FETCH:  if (fetch_done) state <= SQ_LAUNCH;
                default:                   state <= SQ_IDLE;
            endcase
        end
    end

    // Mover-facing outputs come straight from the live descriptor.
    always_comb begin
        busy     = (state != SQ_IDLE);
        mv_start = (state == SQ_LAUNCH);
        mv_src   = cur.src;
        mv_dst   = cur.dst;
        mv_size  = cur.ctrl[SIZE_W-1:0];
    end

    dcs_ctx u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_usr    (load_usr),
        .usr         (usr),
        .capture_end (buf_end),
        .src_end     (mv_src_end),
        .dst_end     (mv_dst_end),
        .load_lli    (fetch_done),
        .lli         (lli),
        .cur         (cur)
    );

    dcs_fetch u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (fetch_go),
        .base      (cur.nxt),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .done      (fetch_done),
        .desc      (lli)
    );

    dcs_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_buf    (buf_end),
        .set_chain  (buf_end && is_last),
        .clr_buf    (clr_buf),
        .clr_chain  (clr_chain),
        .mask_buf   (irq_mask_buf),
        .mask_chain (irq_mask_chain),
        .sts_buf    (sts_buf),
        .sts_chain  (sts_chain),
        .irq_buf    (irq_buf),
        .irq_chain  (irq_chain)
    );

    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start); // R1
    AST_NO_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R2
    AST_CHAIN_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_chain) |-> !busy); // R8
    AST_NO_LAUNCH_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mv_start); // R6
endmodule

// File: tb/dma_chain_seq_test.sv
`timescale 1ns/100ps
module dma_chain_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] usr_src = '0, usr_dst = '0, usr_ctrl = '0, usr_next = '0;
    logic        busy, mv_start;
    logic [31:0] mv_src, mv_dst;
    logic [15:0] mv_size;
    logic        mv_done = 1'b0;
    logic [31:0] mv_src_end = '0, mv_dst_end = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        irq_mask_buf = 1'b0, irq_mask_chain = 1'b0;
    logic        clr_buf = 1'b0, clr_chain = 1'b0;
    logic        sts_buf, sts_chain, irq_buf, irq_chain;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dma_chain_seq uut (.*);

    // Mover model: logs each launch, answers with done three cycles later.
    logic [31:0] lg_src [16];
    logic [31:0] lg_dst [16];
    logic [15:0] lg_size [16];
    int          lg_n = 0;
    int          mv_cnt = 0;
    logic [31:0] run_src, run_dst;
    logic [15:0] run_size;
    always @(posedge clk) begin
        mv_done <= 1'b0;
        if (mv_start) begin
            lg_src[lg_n % 16]  <= mv_src;
            lg_dst[lg_n % 16]  <= mv_dst;
            lg_size[lg_n % 16] <= mv_size;
            lg_n     <= lg_n + 1;
            run_src  <= mv_src;
            run_dst  <= mv_dst;
            run_size <= mv_size;
            mv_cnt   <= 3;
        end else if (mv_cnt != 0) begin
            mv_cnt <= mv_cnt - 1;
            if (mv_cnt == 1) begin
                mv_done    <= 1'b1;
                mv_src_end <= run_src + 32'(run_size) * 4;
                mv_dst_end <= run_dst + 32'(run_size) * 4;
            end
        end
    end

    // Memory model: 64 words, one-cycle acknowledge, logs read addresses.
    logic [31:0] mem [64];
    logic [31:0] fa_log [32];
    int          fa_n = 0;
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[7:2]];
            fa_log[fa_n % 32] <= mem_addr;
            fa_n <= fa_n + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic kick(input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] c, input logic [31:0] n);
        @(negedge clk);
        usr_src = s; usr_dst = d; usr_ctrl = c; usr_next = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_buf = 1'b1; clr_chain = 1'b1;
        @(negedge clk);
        clr_buf = 1'b0; clr_chain = 1'b0;
    endtask

    // Control word: size [15:0], source-continue bit 16, destination-continue bit 17.
    function automatic logic [31:0] ctl(input logic sc, input logic dc, input logic [15:0] sz);
        return {14'd0, dc, sc, sz};
    endfunction

    task automatic t_reset();
        chk("R1", "busy after reset", 32'(busy), 0);
        chk("R1", "mv_start after reset", 32'(mv_start), 0);
        chk("R6", "mem_req after reset", 32'(mem_req), 0);
        chk("R7", "sts_buf after reset", 32'(sts_buf), 0);
        chk("R8", "sts_chain after reset", 32'(sts_chain), 0);
    endtask

    // R1, R2: single buffer with both continue bits set.
    task automatic t_single();
        int base_l = lg_n;
        int base_f = fa_n;
        kick(32'h0000_1000, 32'h0000_2000, ctl(1'b1, 1'b1, 16'd6), 32'h0000_0040);
        chk("R1", "busy after start", 32'(busy), 1);
        wait_idle();
        @(negedge clk);
        chk("R2", "launch count single", 32'(lg_n - base_l), 1);
        chk("R1", "single src", lg_src[base_l % 16], 32'h0000_1000);
        chk("R1", "single dst", lg_dst[base_l % 16], 32'h0000_2000);
        chk("R1", "single size", 32'(lg_size[base_l % 16]), 6);
        chk("R2", "no descriptor read", 32'(fa_n - base_f), 0);
        chk("R7", "sts_buf single", 32'(sts_buf), 1);
        chk("R8", "sts_chain single", 32'(sts_chain), 1);
        chk("R7", "irq_buf masked off", 32'(irq_buf), 0);
        chk("R8", "irq_chain masked off", 32'(irq_chain), 0);
        irq_mask_buf = 1'b1; irq_mask_chain = 1'b1;
        #1;
        chk("R7", "irq_buf unmasked", 32'(irq_buf), 1);
        chk("R8", "irq_chain unmasked", 32'(irq_chain), 1);
        irq_mask_buf = 1'b0; irq_mask_chain = 1'b0;
        clear_all();
        chk("R9", "sts_buf cleared", 32'(sts_buf), 0);
        chk("R9", "sts_chain cleared", 32'(sts_chain), 0);
    endtask

    // R3, R4, R5, R6, R8, R10: four-buffer chain through every mode.
    task automatic t_chain();
        int base_l = lg_n;
        int base_f = fa_n;
        mem[16] = 32'h0000_3000; mem[17] = 32'h0000_4000;
        mem[18] = ctl(1'b0, 1'b1, 16'd8); mem[19] = 32'h0000_0080;
        mem[32] = 32'h0000_5000; mem[33] = 32'hDEAD_0000;
        mem[34] = ctl(1'b1, 1'b0, 16'd2); mem[35] = 32'h0000_00C0;
        mem[48] = 32'hBEEF_0000; mem[49] = 32'h0000_6000;
        mem[50] = ctl(1'b1, 1'b1, 16'd5); mem[51] = 32'h0000_0000;
        kick(32'h0000_1000, 32'h0000_2000, ctl(1'b0, 1'b0, 16'd4), 32'h0000_0040);
        while (lg_n - base_l < 2) @(negedge clk);
        kick(32'h9999_0000, 32'h8888_0000, ctl(1'b1, 1'b1, 16'd1), 32'h0);
        while (lg_n - base_l < 4) @(negedge clk);
        chk("R8", "no chain status before final", 32'(sts_chain), 0);
        chk("R7", "buffer status mid-chain", 32'(sts_buf), 1);
        wait_idle();
        @(negedge clk);
        chk("R10", "launch count chain", 32'(lg_n - base_l), 4);
        chk("R5", "b2 src", lg_src[(base_l + 1) % 16], 32'h0000_3000);
        chk("R5", "b2 dst", lg_dst[(base_l + 1) % 16], 32'h0000_4000);
        chk("R5", "b2 size", 32'(lg_size[(base_l + 1) % 16]), 8);
        chk("R3", "b3 src", lg_src[(base_l + 2) % 16], 32'h0000_5000);
        chk("R3", "b3 dst", lg_dst[(base_l + 2) % 16], 32'h0000_4020);
        chk("R3", "b3 size", 32'(lg_size[(base_l + 2) % 16]), 2);
        chk("R4", "b4 src", lg_src[(base_l + 3) % 16], 32'h0000_5008);
        chk("R4", "b4 dst", lg_dst[(base_l + 3) % 16], 32'h0000_6000);
        chk("R4", "b4 size", 32'(lg_size[(base_l + 3) % 16]), 5);
        chk("R6", "descriptor word reads", 32'(fa_n - base_f), 12);
        for (int k = 0; k < 12; k++)
            chk("R6", "read address", fa_log[(base_f + k) % 32],
                32'h40 * 32'((k / 4) + 1) + 32'(4 * (k % 4)));
        chk("R8", "chain status at end", 32'(sts_chain), 1);
        clear_all();
    endtask

    // R9: a clear held across a buffer completion loses to the set.
    task automatic t_set_wins();
        kick(32'h0000_7000, 32'h0000_7800, ctl(1'b1, 1'b1, 16'd3), 32'h0);
        @(negedge clk);
        clr_buf = 1'b1;
        while (!mv_done) @(negedge clk);
        @(negedge clk);
        chk("R9", "set beats clear", 32'(sts_buf), 1);
        @(negedge clk);
        chk("R9", "clear after set", 32'(sts_buf), 0);
        clr_buf = 1'b0;
        wait_idle();
        clear_all();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_set_wins();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule